// File: doc/BRIEF.md
# Colour-Write Dot Scheduler

When the processor writes a palette colour while the picture is being drawn, the real display shows that colour as a single stray dot at the current beam position. This block reproduces that effect. On each colour write it takes the fetch-side beam position (row and column) and moves it back by the fixed fetch-to-pixel pipeline lag. The position wraps across line and frame edges. The block then queues the resulting screen position together with the written colour.

The pixel output stage supplies its own row and column every cycle. When the head of the queue names exactly that position, the block raises an overlay-valid flag with the queued colour for one cycle, and the output stage mixes it into the border or picture. If the head's row matches but its column has already passed, the entry is stale and is dropped so it does not hold up the queue. A write that arrives while the queue is full is lost, and a one-cycle overflow pulse reports the loss.

The queue is controlled by a three-state machine. The states are EMPTY, PART (some entries held) and FULL. The transitions are:
- FIRST_PUSH: EMPTY to PART.
- FILL: PART to FULL, when the last free slot is taken.
- DRAIN: FULL to PART, on a pop without a push.
- LAST_POP: PART to EMPTY, when the only entry leaves.

Top module: `cram_dot_sched`

## Requirements
- R1: After reset, `dot_valid` is 0, `dot_colour` is 0 and `overflow` is 0.
- R2: For a write at fetch column c with c >= 11 and c - 11 < 342, the dot lands at the same row, column c - 11.
- R3: For a write at fetch column c < 11, the dot lands at column c - 11 + 342 on the previous row. Row 0 wraps to the last row, which is 261.
- R4: For a fetch column c with c - 11 >= 342, the dot lands at column c - 11 - 342 on the next row. The last row, 261, wraps to row 0.
- R5: The emitted `dot_colour` equals the 6-bit `cram_data` given with the write. `dot_colour` is 0 whenever `dot_valid` is 0.
- R6: `dot_valid` rises for one cycle, one cycle after the clock edge at which `rd_row`/`rd_col` equal the head entry's position. The entry is then removed.
- R7: Entries are emitted in write order. Only the head is compared against the output position.
- R8: If the head's row equals `rd_row` and its column is less than `rd_col`, the head is discarded without output.
- R9: The queue holds 4 entries. A write while it is full is dropped, and `overflow` is 1 for one cycle in the cycle after that write.
- R10: A head whose row differs from `rd_row` is neither emitted nor discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_row | input | 9 | Fetch-side row |
| wr_col | input | 9 | Fetch-side column |
| cram_we | input | 1 | Colour write event |
| cram_data | input | 6 | Colour value written |
| rd_row | input | 9 | Output-side row |
| rd_col | input | 9 | Output-side column |
| dot_valid | output | 1 | Overlay colour valid for this pixel period |
| dot_colour | output | 6 | Overlay colour |
| overflow | output | 1 | Pulse: a write was dropped |

## Verification
A write sampled at one edge is in the queue before the next edge. Its dot can therefore match an output position presented in the very next cycle, and the match shows on `dot_valid` one cycle after the edge that saw it. `overflow` is likewise due one cycle after the dropped write. The bench drives on falling edges and samples on the following falling edge, so each registered result is read exactly one edge after its cause. A further cycle later it confirms that `dot_valid` has fallen again.

// File: rtl/cram_dot_pkg.sv
package cram_dot_pkg;
    localparam int ROW_W    = 9;
    localparam int COL_W    = 9;
    localparam int COLOUR_W = 6;

    typedef struct packed {
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic [COLOUR_W-1:0] colour;
    } dot_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_t;
endpackage

// File: rtl/cram_dot_place.sv
module cram_dot_place
    import cram_dot_pkg::*;
#(
    parameter int COLS = 342,
    parameter int ROWS = 262,
    parameter int LAG  = 11
) (
    input  logic [ROW_W-1:0] in_row,
    input  logic [COL_W-1:0] in_col,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col
);
    localparam int EXT_W = COL_W + 2;
    localparam logic [EXT_W-1:0] OFS   = EXT_W'(COLS - LAG);
    localparam logic [EXT_W-1:0] ONE_L = EXT_W'(COLS);
    localparam logic [EXT_W-1:0] TWO_L = EXT_W'(2 * COLS);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [EXT_W-1:0] biased;

    always_comb begin
        biased = {2'b00, in_col} + OFS;
        if (biased < ONE_L) begin
            // fetch column minus lag went negative: previous line
            out_col = COL_W'(biased);
            out_row = (in_row == '0) ? LAST_ROW : in_row - 1'b1;
        end else if (biased < TWO_L) begin
            out_col = COL_W'(biased - ONE_L);
            out_row = in_row;
        end else begin
            // carried past the line end: next line
            out_col = COL_W'(biased - TWO_L);
            out_row = (in_row == LAST_ROW) ? '0 : in_row + 1'b1;
        end
    end
endmodule

// File: rtl/cram_dot_fifo.sv
module cram_dot_fifo
    import cram_dot_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  dot_t push_dot,
    input  logic pop,
    output dot_t head,
    output logic empty,
    output logic full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    dot_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    qstate_t          state_q, state_d;
    logic             push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (push_ok) state_d = Q_PART;                        // FIRST_PUSH
            Q_PART: begin
                if (push_ok && !pop_ok && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = Q_FULL;                                      // FILL
                else if (pop_ok && !push_ok && cnt_q == CNT_W'(1))
                    state_d = Q_EMPTY;                                     // LAST_POP
            end
            Q_FULL: if (pop_ok && !push_ok) state_d = Q_PART;              // DRAIN
            default: state_d = Q_EMPTY;
        endcase
    end

    // state register and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            cnt_q   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_dot;
    end

    // outputs decoded from state
    always_comb begin
        empty = (state_q == Q_EMPTY);
        full  = (state_q == Q_FULL);
    end

    // R9: state machine and occupancy counter agree
    a_r9_state_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL) == (cnt_q == CNT_W'(DEPTH)));
    // R9: a blocked push leaves the queue full
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    // R1: empty state means no stored entries
    a_r1_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (cnt_q == '0));
endmodule

// File: rtl/cram_dot_sched.sv
module cram_dot_sched
    import cram_dot_pkg::*;
#(
    parameter int COLS  = 342,
    parameter int ROWS  = 262,
    parameter int LAG   = 11,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_W-1:0]    wr_row,
    input  logic [COL_W-1:0]    wr_col,
    input  logic                cram_we,
    input  logic [COLOUR_W-1:0] cram_data,
    input  logic [ROW_W-1:0]    rd_row,
    input  logic [COL_W-1:0]    rd_col,
    output logic                dot_valid,
    output logic [COLOUR_W-1:0] dot_colour,
    output logic                overflow
);
    logic [ROW_W-1:0] place_row;
    logic [COL_W-1:0] place_col;
    dot_t             new_dot, head;
    logic             q_empty, q_full;
    logic             hit, stale, pop;

    cram_dot_place #(.COLS(COLS), .ROWS(ROWS), .LAG(LAG)) u_place (
        .in_row (wr_row),
        .in_col (wr_col),
        .out_row(place_row),
        .out_col(place_col)
    );

    assign new_dot = '{row: place_row, col: place_col, colour: cram_data};

    cram_dot_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (cram_we),
        .push_dot(new_dot),
        .pop     (pop),
        .head    (head),
        .empty   (q_empty),
        .full    (q_full)
    );

    always_comb begin
        hit   = !q_empty && (head.row == rd_row) && (head.col == rd_col);
        stale = !q_empty && (head.row == rd_row) && (head.col <  rd_col);
        pop   = hit || stale;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_valid  <= 1'b0;
            dot_colour <= '0;
            overflow   <= 1'b0;
        end else begin
            dot_valid  <= hit;
            dot_colour <= hit ? head.colour : '0;
            overflow   <= cram_we && q_full;
        end
    end

    // R8: only a non-empty queue is popped
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !q_empty);
    // R6: an overlay pulse needs a queued entry one cycle earlier
    a_r6_valid_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        dot_valid |-> $past(!q_empty));
    // R9: drop report only follows a full queue
    a_r9_ovf_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(q_full));
    // R2: placed column always inside the line
    a_r2_col_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        place_col < COL_W'(COLS));
endmodule

// File: tb/tb_cram_dot_sched.sv
module tb_cram_dot_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] wr_row = '0, wr_col = '0, rd_row = 9'd511, rd_col = '0;
    logic       cram_we = 1'b0;
    logic [5:0] cram_data = '0;
    logic       dot_valid, overflow;
    logic [5:0] dot_colour;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    cram_dot_sched dut (
        .clk(clk), .rst_n(rst_n), .wr_row(wr_row), .wr_col(wr_col),
        .cram_we(cram_we), .cram_data(cram_data), .rd_row(rd_row), .rd_col(rd_col),
        .dot_valid(dot_valid), .dot_colour(dot_colour), .overflow(overflow)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // write a colour; overflow is due one edge later
    task automatic push(input int row, input int col, input int colour, input int exp_ovf);
        @(negedge clk);
        wr_row = 9'(row); wr_col = 9'(col); cram_data = 6'(colour); cram_we = 1'b1;
        @(negedge clk);
        cram_we = 1'b0;
        check("R9 overflow", int'(overflow), exp_ovf);
    endtask

    // present an output position for one cycle; result due one edge later
    task automatic probe(input string req, input int row, input int col,
                         input int exp_v, input int exp_c);
        rd_row = 9'(row); rd_col = 9'(col);
        @(negedge clk);
        rd_row = 9'd511;
        check({req, " valid"}, int'(dot_valid), exp_v);
        check({req, " colour"}, int'(dot_colour), exp_c);
        if (exp_v != 0) begin
            @(negedge clk);
            check("R6 single pulse", int'(dot_valid), 0);
        end
    endtask

    task automatic t_reset();
        check("R1 valid", int'(dot_valid), 0);
        check("R1 colour", int'(dot_colour), 0);
        check("R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_same_row();
        push(5, 100, 6'h2A, 0);
        probe("R8 not yet reached", 5, 88, 0, 0);
        probe("R2 R5 same row", 5, 89, 1, 6'h2A);
        probe("R6 removed", 5, 89, 0, 0);
    endtask

    task automatic t_prev_row();
        push(7, 4, 6'h11, 0);
        probe("R3 previous row", 6, 335, 1, 6'h11);
        push(0, 0, 6'h07, 0);
        probe("R3 row zero wrap", 261, 331, 1, 6'h07);
    endtask

    task automatic t_next_row();
        push(3, 360, 6'h15, 0);
        probe("R4 next row", 4, 7, 1, 6'h15);
        push(261, 400, 6'h3F, 0);
        probe("R4 last row wrap", 0, 47, 1, 6'h3F);
    endtask

    task automatic t_row_mismatch();
        push(10, 50, 6'h09, 0);
        probe("R10 other row", 11, 39, 0, 0);
        probe("R10 kept", 10, 39, 1, 6'h09);
    endtask

    task automatic t_stale();
        push(12, 60, 6'h01, 0);
        push(12, 80, 6'h02, 0);
        probe("R8 stale dropped", 12, 55, 0, 0);
        probe("R8 next emitted", 12, 69, 1, 6'h02);
    endtask

    task automatic t_order();
        push(20, 30, 6'h21, 0);
        push(20, 20, 6'h22, 0);
        probe("R7 only head", 20, 9, 0, 0);
        probe("R7 first out", 20, 19, 1, 6'h21);
        probe("R7 second out", 20, 9, 1, 6'h22);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 4; i++) push(30 + i, 100, i + 1, 0);
        push(34, 100, 6'h30, 1);
        @(negedge clk);
        check("R9 overflow one cycle", int'(overflow), 0);
        for (int i = 0; i < 4; i++) probe("R9 kept entry", 30 + i, 89, 1, i + 1);
        probe("R9 dropped entry", 34, 89, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_same_row();
        t_prev_row();
        t_next_row();
        t_row_mismatch();
        t_stale();
        t_order();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule